// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block gathers a set of peripheral interrupt request lines and presents a single interrupt to a processor together with the address of the service routine's entry slot. Each request line is turned into a sticky pending bit on its rising edge. The pending bits pass through a software-written enable mask. A fixed-priority encoder then picks the lowest-numbered unmasked pending source.

The winning source number is zero-extended and scaled by the vector slot size to form the vector address. With four sources and four-byte slots, the vector addresses are 0, 4, 8 and 12. The processor tests the interrupt output at its own instruction boundaries, so a request stays pending until the processor acknowledges it. On an acknowledge, the winner's vector is captured and its pending bit is cleared. A global enable input lets the service routine hold the interrupt output low while it runs.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all pending bits and all mask bits are zero, `cpuIrq` is low and `vecAddr` is zero.
- R2: A 0-to-1 change on `irqReq[i]` sets pending bit i at the next clock edge. A line that stays high sets its bit only once. It must fall and rise again to set the bit a second time.
- R3: A pending bit stays set until an acknowledge selects its source. A request line that falls does not clear it.
- R4: When `intAck` is high at a clock edge and at least one unmasked source is pending, `vecAddr` becomes the winner's index times `SLOT_BYTES`, with all other bits zero. The winner is the lowest-numbered unmasked pending source, so source 0 has the highest priority. For four sources and four-byte slots the vector addresses are 0, 4, 8 and 12. The captured value holds while unmasked pending sources remain and no further acknowledge arrives, even when a higher-priority request arrives in the acknowledge cycle.
- R5: `cpuIrq` is high exactly when `globalEn` is high and at least one pending source is unmasked. `globalEn` acts on `cpuIrq` in the same cycle, with no register in between.
- R6: An acknowledge clears only the pending bit of the source it selects. All other pending bits are left as they are.
- R7: When `maskWrEn` is high at a clock edge, `maskWrData` is loaded into the mask. A mask bit of 1 enables its source. A masked source still records pending on its rising edge, and it raises `cpuIrq` once its mask bit is set.
- R8: At an edge where no unmasked source is pending and no acknowledge is taken, `vecAddr` becomes zero. An acknowledge with no unmasked pending source changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irqReq | input | NUM_SRC | Interrupt request lines, one per source |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | NUM_SRC | New mask value, 1 enables a source |
| globalEn | input | 1 | Global interrupt enable for `cpuIrq` |
| intAck | input | 1 | Processor acknowledge of the current interrupt |
| cpuIrq | output | 1 | Interrupt request to the processor |
| vecAddr | output | ADDR_W | Vector address of the acknowledged source |

## Verification
Pending, mask and vector state are registered, so each of them changes at the first clock edge after an input is applied. This applies to a request edge, a mask write and an acknowledge. `cpuIrq` follows that registered state at the same edge, but it follows `globalEn` with no delay. The bench drives inputs on the falling edge. For each step it queues the expected `cpuIrq` and `vecAddr` tagged with the index of the rising edge at which they become due. A monitor compares them one nanosecond after that edge, before any input can move. The stimulus sequence covers several cases: an acknowledge that coincides with a new higher-priority request, a winner at index 0 whose vector is zero, an acknowledge with nothing to take, and a pending source that was masked and is later enabled.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  // Strobes from control to datapath, valid for one clock edge.
  typedef struct packed {
    logic clearWin;  // drop the pending bit of the current winner
    logic loadVec;   // capture the winner's vector address
    logic zeroVec;   // force the vector register to zero
  } ivcStrobe_t;

endpackage

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] actVec,
  output logic               hit,
  output logic [NUM_SRC-1:0] grant,
  output logic [IDX_W-1:0]   winIdx
);

  // lowerAny[i] is high when any source below i is active.
  logic [NUM_SRC:0] lowerAny;
  assign lowerAny[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign lowerAny[g+1] = lowerAny[g] | actVec[g];
    assign grant[g]      = actVec[g] & ~lowerAny[g];
  end

  assign hit = lowerAny[NUM_SRC];

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) winIdx = winIdx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/ivc_control.sv
module ivc_control
  import ivc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       globalEn,
  input  logic       intAck,
  input  logic       anyActive,
  output logic       cpuIrq,
  output ivcStrobe_t strb
);

  logic takeAck;

  assign takeAck       = intAck & anyActive;
  assign strb.clearWin = takeAck;
  assign strb.loadVec  = takeAck;
  assign strb.zeroVec  = ~takeAck & ~anyActive;

  assign cpuIrq = globalEn & anyActive;

  // R5: a low global enable keeps the interrupt output low
  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !globalEn |-> !cpuIrq);

  // R8: an acknowledge with nothing active never loads the vector
  p_no_load_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (intAck && !anyActive) |-> !strb.loadVec);

endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int ADDR_W     = 32,
  parameter int SLOT_BYTES = 4,
  localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int SLOT_SHIFT = $clog2(SLOT_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  ivcStrobe_t         strb,
  output logic               anyActive,
  output logic [ADDR_W-1:0]  vecAddr
);

  logic [NUM_SRC-1:0] prevReq;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] riseVec;
  logic [NUM_SRC-1:0] activeVec;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] clearVec;
  logic [IDX_W-1:0]   winIdx;
  logic [ADDR_W-1:0]  vecReg;
  logic [ADDR_W-1:0]  winAddr;

  assign riseVec   = irqReq & ~prevReq;
  assign activeVec = pending & maskReg;
  assign clearVec  = strb.clearWin ? grant : '0;
  assign winAddr   = ADDR_W'(winIdx) << SLOT_SHIFT;

  ivc_prio_enc #(
    .NUM_SRC(NUM_SRC),
    .IDX_W  (IDX_W)
  ) i_enc (
    .actVec(activeVec),
    .hit   (anyActive),
    .grant (grant),
    .winIdx(winIdx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevReq <= '0;
      pending <= '0;
      maskReg <= '0;
    end else begin
      prevReq <= irqReq;
      pending <= (pending & ~clearVec) | riseVec;
      if (maskWrEn) maskReg <= maskWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vecReg <= '0;
    end else if (strb.loadVec) begin
      vecReg <= winAddr;
    end else if (strb.zeroVec) begin
      vecReg <= '0;
    end
  end

  assign vecAddr = vecReg;

  // R2: a request edge leaves its pending bit set
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (riseVec != '0) |=> ((pending & $past(riseVec)) == $past(riseVec)));

  // R3: without an acknowledge no pending bit is lost
  p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clearWin |=> ((pending & $past(pending)) == $past(pending)));

  // R4: the encoder's winner is one of the active sources
  p_win_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    anyActive |-> activeVec[winIdx]);

  // R4: an acknowledge captures the winner's scaled index
  p_ack_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadVec |=> (vecAddr == (ADDR_W'($past(winIdx)) << SLOT_SHIFT)));

  // R6: the acknowledged bit drops unless a new edge re-arms it
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clearWin && ((grant & riseVec) == '0)) |=> ((pending & $past(grant)) == '0));

  // R7: a mask write lands in the mask register
  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    maskWrEn |=> (maskReg == $past(maskWrData)));

  // R8: idle edges return the vector to zero
  p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyActive && !strb.loadVec) |=> (vecAddr == '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int ADDR_W     = 32,
  parameter int SLOT_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic               globalEn,
  input  logic               intAck,
  output logic               cpuIrq,
  output logic [ADDR_W-1:0]  vecAddr
);

  ivcStrobe_t strb;
  logic       anyActive;

  ivc_control i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .globalEn (globalEn),
    .intAck   (intAck),
    .anyActive(anyActive),
    .cpuIrq   (cpuIrq),
    .strb     (strb)
  );

  ivc_datapath #(
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .SLOT_BYTES(SLOT_BYTES)
  ) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .irqReq    (irqReq),
    .maskWrEn  (maskWrEn),
    .maskWrData(maskWrData),
    .strb      (strb),
    .anyActive (anyActive),
    .vecAddr   (vecAddr)
  );

  // R1: reset leaves the processor side quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!cpuIrq && vecAddr == '0));

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irqReq = '0;
  logic        maskWrEn = 1'b0;
  logic [3:0]  maskWrData = '0;
  logic        globalEn = 1'b0;
  logic        intAck = 1'b0;
  logic        cpuIrq;
  logic [31:0] vecAddr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic        eIrq;
    logic [31:0] eVec;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irqReq    (irqReq),
    .maskWrEn  (maskWrEn),
    .maskWrData(maskWrData),
    .globalEn  (globalEn),
    .intAck    (intAck),
    .cpuIrq    (cpuIrq),
    .vecAddr   (vecAddr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input string tag, input logic eIrq, input logic [31:0] eVec);
    checks++;
    if (cpuIrq !== eIrq || vecAddr !== eVec) begin
      failures++;
      $display("FAIL %s: cpuIrq=%b vecAddr=%0d expected cpuIrq=%b vecAddr=%0d",
               tag, cpuIrq, vecAddr, eIrq, eVec);
    end
  endtask

  // Monitor: results of the inputs applied before an edge are due just after it.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0 && expQ[0].due == cyc) begin
      expItem_t it;
      it = expQ.pop_front();
      compare(it.tag, it.eIrq, it.eVec);
    end
  end

  // Driver: apply one step on the falling edge and queue its expectation.
  task automatic step(input logic [3:0] req, input logic mWe, input logic [3:0] mData,
                      input logic gEn, input logic ack,
                      input logic eIrq, input logic [31:0] eVec, input string tag);
    @(negedge clk);
    irqReq     = req;
    maskWrEn   = mWe;
    maskWrData = mData;
    globalEn   = gEn;
    intAck     = ack;
    expQ.push_back('{cyc + 1, eIrq, eVec, tag});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 during reset", 1'b0, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 after reset", 1'b0, 32'd0);

    step(4'b0000, 1, 4'b1111, 1, 0, 0, 0,  "R7 mask enable all");
    step(4'b0100, 0, 4'b0000, 1, 0, 1, 0,  "R2/R5 source 2 raises irq");
    step(4'b0000, 0, 4'b0000, 1, 0, 1, 0,  "R3 request fall keeps pending");
    step(4'b0000, 0, 4'b0000, 0, 0, 0, 0,  "R5 global disable");
    step(4'b0000, 0, 4'b0000, 1, 1, 0, 8,  "R4/R6 ack source 2 vector 8");
    step(4'b0000, 0, 4'b0000, 1, 0, 0, 0,  "R8 idle vector zero");
    step(4'b1010, 0, 4'b0000, 1, 0, 1, 0,  "R2 sources 1 and 3");
    step(4'b1011, 0, 4'b0000, 1, 1, 1, 4,  "R4/R6 ack picks 1 while 0 arrives");
    step(4'b1011, 0, 4'b0000, 1, 0, 1, 4,  "R4 captured vector holds");
    step(4'b1011, 0, 4'b0000, 1, 1, 1, 0,  "R4 source 0 wins vector 0");
    step(4'b1011, 0, 4'b0000, 1, 1, 0, 12, "R4 source 3 vector 12");
    step(4'b1011, 0, 4'b0000, 1, 0, 0, 0,  "R2 held lines do not re-pend");
    step(4'b0000, 1, 4'b0000, 1, 0, 0, 0,  "R7 mask all off");
    step(4'b0100, 0, 4'b0000, 1, 0, 0, 0,  "R7 masked edge gives no irq");
    step(4'b0100, 0, 4'b0000, 1, 1, 0, 0,  "R8 ack with nothing unmasked");
    step(4'b0100, 1, 4'b0100, 1, 0, 1, 0,  "R7/R8 unmask shows kept pending");
    step(4'b0100, 0, 4'b0000, 1, 1, 0, 8,  "R4/R6 ack unmasked source 2");
    step(4'b0000, 0, 4'b0000, 1, 0, 0, 0,  "R8 idle again");

    @(negedge clk);
    intAck = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: cycles=%0d expected completion earlier", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule